// File: doc/BRIEF.md
# Host Byte Exchange Port

This block connects an external host processor to an on-chip controller through an asynchronous 8-bit slave port. The host drives an active-low chip select, active-low read and write strobes, and one select bit. A low select bit picks the data byte. A high select bit picks the status byte. The port drives the data bus only while a read is in progress. An interrupt request tells the host that a byte is waiting for it.

On the core side there are two one-byte registers. The outbound register is filled with a load strobe. The inbound register carries a valid flag and is emptied with a consume strobe. A core ready input lets the controller refuse host bytes even when the inbound register is empty.

The host strobes are brought into the core clock through a synchronizer of `SYNC_STAGES` flops. Each access takes effect when its synchronized strobe ends. The core clock period must be short enough that a 50 ns strobe spans at least two rising clock edges. A 20 ns period meets this.

Top module: `hostParPort`

## Requirements
- R1: `hostDataOe` is high exactly while `hostCsN` and `hostRdN` are both low. A write access, or a strobe with `hostCsN` high, never enables the bus.
- R2: A read with `hostSel`=1 returns the status byte: bit 7 is the transmit-empty flag, bit 6 is the receive-full flag, and bits 5..0 read as zero.
- R3: After reset the transmit-empty flag is 1, `hostIrq` is 0, `rxValid` is 0 and `rxOverflow` is 0.
- R4: A `txLoad` pulse while `txEmpty`=1 stores `txData`. At the next clock edge `txEmpty` becomes 0 and `hostIrq` becomes 1.
- R5: A read with `hostSel`=0 returns the pending outbound byte. Within three core clocks after the read strobe ends, `txEmpty` returns to 1 and `hostIrq` drops to 0.
- R6: A status read (`hostSel`=1) does not change the transmit-empty flag or `hostIrq`.
- R7: A host write that ends while receive-full is 0 presents the written byte on `rxData`, with `rxValid`=1, within three core clocks of the rising edge of `hostWrN`. The byte and the flag then hold until the byte is consumed.
- R8: The receive-full flag (status bit 6) is 1 whenever `rxValid` is 1 or `coreReady` is 0, and 0 otherwise.
- R9: A host write that ends while receive-full is 1 is dropped: `rxData` and `rxValid` keep their values. `rxOverflow` is set and stays set until reset.
- R10: A `rxConsume` pulse while `rxValid`=1 clears `rxValid` at the next clock edge.
- R11: A `txLoad` pulse while `txEmpty`=0 is ignored. The pending byte the host reads afterwards is the earlier one.
- R12: A read or write strobe 50 ns wide with a 20 ns core clock is acted on. Strobes with `hostCsN` high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostSel | input | 1 | Host select bit: 0 data, 1 status |
| hostDataIn | input | DATA_W | Host bus, inbound value |
| hostDataOut | output | DATA_W | Host bus, value to drive |
| hostDataOe | output | 1 | Host bus drive enable |
| hostIrq | output | 1 | High while an outbound byte is pending |
| txData | input | DATA_W | Outbound byte from the core |
| txLoad | input | 1 | Load strobe for `txData` |
| txEmpty | output | 1 | Outbound register free |
| rxData | output | DATA_W | Inbound byte from the host |
| rxValid | output | 1 | Inbound byte present |
| rxConsume | input | 1 | Core takes the inbound byte |
| coreReady | input | 1 | Core willing to accept host bytes |
| rxOverflow | output | 1 | Sticky flag: a host write was dropped |

## Verification
The checker assumes the core pulses `rxConsume` and `txLoad` for single clocks. It also assumes the host holds `hostSel` and `hostDataIn` steady for the whole time a strobe is active, and never overlaps a read with a write. The stimulus changes host pins only after a falling clock edge. Every strobe it issues is at least 50 ns wide, with `hostCsN` set up before the strobe and released after it. Accesses are spaced five core clocks apart, so each access has finished through the synchronizer before the next one begins.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  // decisions the control hands to the datapath for one clock
  typedef struct packed {
    logic loadTx;     // core byte accepted into outbound register
    logic releaseTx;  // host finished reading the pending byte
    logic acceptRx;   // host write taken into inbound register
    logic dropRx;     // host write refused, mark overflow
    logic consumeRx;  // core took the inbound byte
  } hpStrobes_t;
endpackage

// File: rtl/hpSync.sv
module hpSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[LAST];
endmodule

// File: rtl/hpCtrl.sv
module hpCtrl
  import hpp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdSync,
  input  logic       wrSync,
  input  logic       selLatched,
  input  logic       txEmpty,
  input  logic       rxFull,
  input  logic       rxValid,
  input  logic       txLoad,
  input  logic       rxConsume,
  output hpStrobes_t strb
);
  logic rdPrev;
  logic wrPrev;
  logic rdEnd;
  logic wrEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= rdSync;
      wrPrev <= wrSync;
    end
  end

  // an access completes when its synchronized strobe falls
  assign rdEnd = rdPrev & ~rdSync;
  assign wrEnd = wrPrev & ~wrSync;

  always_comb begin
    strb           = '0;
    strb.loadTx    = txLoad & txEmpty;
    strb.releaseTx = rdEnd & ~selLatched & ~txEmpty;
    strb.acceptRx  = wrEnd & ~rxFull;
    strb.dropRx    = wrEnd & rxFull;
    strb.consumeRx = rxConsume & rxValid;
  end
endmodule

// File: rtl/hpData.sv
module hpData
  import hpp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpStrobes_t        strb,
  input  logic              rdActive,
  input  logic              wrActive,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] txData,
  input  logic              coreReady,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              hostIrq,
  output logic              selLatched,
  output logic              txEmpty,
  output logic              rxFull,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxOverflow
);
  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] txReg;
  logic              teReg;
  logic [DATA_W-1:0] rxReg;
  logic              rxValidReg;
  logic              ovfReg;
  logic [DATA_W-1:0] wrShadow;
  logic              selReg;
  logic [DATA_W-1:0] statusByte;

  // host-side values held while the raw strobe is active
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrShadow <= '0;
      selReg   <= 1'b0;
    end else begin
      if (wrActive) wrShadow <= hostDataIn;
      if (rdActive) selReg   <= hostSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= '0;
      teReg <= 1'b1;
    end else if (strb.loadTx) begin
      txReg <= txData;
      teReg <= 1'b0;
    end else if (strb.releaseTx) begin
      teReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg      <= '0;
      rxValidReg <= 1'b0;
      ovfReg     <= 1'b0;
    end else begin
      if (strb.acceptRx) begin
        rxReg      <= wrShadow;
        rxValidReg <= 1'b1;
      end else if (strb.consumeRx) begin
        rxValidReg <= 1'b0;
      end
      if (strb.dropRx) ovfReg <= 1'b1;
    end
  end

  assign rxFull     = rxValidReg | ~coreReady;
  assign statusByte = {teReg, rxFull, {PAD_W{1'b0}}};

  assign hostDataOut = hostSel ? statusByte : txReg;
  assign hostDataOe  = rdActive;
  assign hostIrq     = ~teReg;
  assign selLatched  = selReg;
  assign txEmpty     = teReg;
  assign rxData      = rxReg;
  assign rxValid     = rxValidReg;
  assign rxOverflow  = ovfReg;
endmodule

// File: rtl/hostParPort.sv
module hostParPort
  import hpp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              hostIrq,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxConsume,
  input  logic              coreReady,
  output logic              rxOverflow
);
  logic       rdActive;
  logic       wrActive;
  logic       rdSync;
  logic       wrSync;
  logic       selLatched;
  logic       rxFull;
  hpStrobes_t strb;

  assign rdActive = ~hostCsN & ~hostRdN;
  assign wrActive = ~hostCsN & ~hostWrN;

  hpSync #(.STAGES(SYNC_STAGES)) u_rdSync (
    .clk(clk), .rstN(rstN), .asyncIn(rdActive), .syncOut(rdSync)
  );

  hpSync #(.STAGES(SYNC_STAGES)) u_wrSync (
    .clk(clk), .rstN(rstN), .asyncIn(wrActive), .syncOut(wrSync)
  );

  hpCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdSync(rdSync), .wrSync(wrSync),
    .selLatched(selLatched), .txEmpty(txEmpty), .rxFull(rxFull),
    .rxValid(rxValid), .txLoad(txLoad), .rxConsume(rxConsume),
    .strb(strb)
  );

  hpData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdActive(rdActive),
    .wrActive(wrActive), .hostSel(hostSel), .hostDataIn(hostDataIn),
    .txData(txData), .coreReady(coreReady), .hostDataOut(hostDataOut),
    .hostDataOe(hostDataOe), .hostIrq(hostIrq), .selLatched(selLatched),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxData(rxData),
    .rxValid(rxValid), .rxOverflow(rxOverflow)
  );
endmodule

// File: rtl/hostParPort_chk.sv
module hostParPort_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostCsN,
  input logic              hostRdN,
  input logic              hostSel,
  input logic [DATA_W-1:0] hostDataOut,
  input logic              hostDataOe,
  input logic              hostIrq,
  input logic              txLoad,
  input logic              txEmpty,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic              rxConsume,
  input logic              rxOverflow
);
  // R1
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostCsN && !hostRdN) |-> hostDataOe);
  // R1
  bus_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsN || hostRdN) |-> !hostDataOe);
  // R2
  status_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostDataOe && hostSel) |-> (hostDataOut[DATA_W-3:0] == '0));
  // R4
  load_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && txEmpty) |=> (hostIrq && !txEmpty));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxConsume) |=> (rxValid && $stable(rxData)));
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow |=> rxOverflow);
  // R10
  consume_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxConsume && rxValid) |=> !rxValid);
endmodule

bind hostParPort hostParPort_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
  .hostSel(hostSel), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
  .hostIrq(hostIrq), .txLoad(txLoad), .txEmpty(txEmpty), .rxData(rxData),
  .rxValid(rxValid), .rxConsume(rxConsume), .rxOverflow(rxOverflow)
);

// File: tb/sim_hostParPort.sv
`timescale 1ns/1ps
module sim_hostParPort;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostCsN = 1'b1;
  logic       hostRdN = 1'b1;
  logic       hostWrN = 1'b1;
  logic       hostSel = 1'b0;
  logic [7:0] hostDataIn = '0;
  logic [7:0] hostDataOut;
  logic       hostDataOe;
  logic       hostIrq;
  logic [7:0] txData = '0;
  logic       txLoad = 1'b0;
  logic       txEmpty;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxConsume = 1'b0;
  logic       coreReady = 1'b1;
  logic       rxOverflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expQ[$];

  always #10 clk = ~clk;

  hostParPort u0 (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostSel(hostSel), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .hostIrq(hostIrq),
    .txData(txData), .txLoad(txLoad), .txEmpty(txEmpty), .rxData(rxData),
    .rxValid(rxValid), .rxConsume(rxConsume), .coreReady(coreReady),
    .rxOverflow(rxOverflow)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: each new inbound byte is compared against the scoreboard queue
  initial begin
    logic prevValid;
    prevValid = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && rxValid && !prevValid) begin
        if (expQ.size() == 0) chk("R7 unexpected rx byte", rxData, 8'hxx);
        else chk("R7 rx byte", rxData, expQ.pop_front());
      end
      prevValid = rxValid;
    end
  end

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // host write, 50 ns strobe; expectAccept pushes onto the scoreboard
  task automatic hostWrite(input logic [7:0] val, input bit expectAccept, input bit useCs);
    @(negedge clk);
    hostDataIn = val;
    hostSel = 1'b0;
    hostCsN = !useCs;
    #5 hostWrN = 1'b0;
    if (expectAccept) expQ.push_back(val);
    #25 chk("R1 no drive on write", {7'b0, hostDataOe}, 8'h00);
    #25 hostWrN = 1'b1;
    #5 hostCsN = 1'b1;
    settle();
  endtask

  task automatic hostRead(input logic sel, input bit useCs, output logic [7:0] val, output logic oe);
    @(negedge clk);
    hostSel = sel;
    hostCsN = !useCs;
    #5 hostRdN = 1'b0;
    #30 val = hostDataOut;
    oe = hostDataOe;
    #20 hostRdN = 1'b1;
    #5 hostCsN = 1'b1;
    settle();
  endtask

  task automatic coreLoad(input logic [7:0] val);
    @(negedge clk);
    txData = val;
    txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  task automatic coreConsume();
    @(negedge clk);
    rxConsume = 1'b1;
    @(negedge clk);
    rxConsume = 1'b0;
    chk("R10 rxValid cleared", {7'b0, rxValid}, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R3 txEmpty", {7'b0, txEmpty}, 8'h01);
    chk("R3 irq", {7'b0, hostIrq}, 8'h00);
    chk("R3 rxValid", {7'b0, rxValid}, 8'h00);
    chk("R3 overflow", {7'b0, rxOverflow}, 8'h00);
    chk("R1 idle oe", {7'b0, hostDataOe}, 8'h00);

    hostRead(1'b1, 1'b1, v, oe);
    chk("R2 R8 status idle", v, 8'h80);
    chk("R1 oe during read", {7'b0, oe}, 8'h01);
    chk("R1 oe after read", {7'b0, hostDataOe}, 8'h00);
    coreReady = 1'b0;
    hostRead(1'b1, 1'b1, v, oe);
    chk("R8 status not ready", v, 8'hC0);
    hostWrite(8'h11, 1'b0, 1'b1);
    chk("R9 dropped while not ready", {7'b0, rxValid}, 8'h00);
    chk("R9 overflow set", {7'b0, rxOverflow}, 8'h01);
    coreReady = 1'b1;

    coreLoad(8'hA5);
    chk("R4 txEmpty low", {7'b0, txEmpty}, 8'h00);
    chk("R4 irq high", {7'b0, hostIrq}, 8'h01);
    hostRead(1'b1, 1'b1, v, oe);
    chk("R2 status pending", v, 8'h00);
    chk("R6 irq after status read", {7'b0, hostIrq}, 8'h01);
    coreLoad(8'h3C);
    chk("R11 txEmpty stays low", {7'b0, txEmpty}, 8'h00);
    hostRead(1'b0, 1'b0, v, oe);
    chk("R12 read without cs no drive", {7'b0, oe}, 8'h00);
    chk("R12 irq kept", {7'b0, hostIrq}, 8'h01);
    hostRead(1'b0, 1'b1, v, oe);
    chk("R5 R11 pending byte", v, 8'hA5);
    chk("R5 irq cleared", {7'b0, hostIrq}, 8'h00);
    chk("R5 txEmpty set", {7'b0, txEmpty}, 8'h01);

    hostWrite(8'h5A, 1'b1, 1'b1);
    chk("R7 rxValid", {7'b0, rxValid}, 8'h01);
    hostRead(1'b1, 1'b1, v, oe);
    chk("R8 status full", v, 8'hC0);
    hostWrite(8'h77, 1'b0, 1'b1);
    chk("R9 rxData kept", rxData, 8'h5A);
    chk("R9 overflow sticky", {7'b0, rxOverflow}, 8'h01);
    coreConsume();
    hostWrite(8'h99, 1'b0, 1'b0);
    chk("R12 write without cs ignored", {7'b0, rxValid}, 8'h00);

    foreach (expQ[i]) chk("R7 queue drained", 8'h01, 8'h00);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h81 + 8'(k);
      hostWrite(b, 1'b1, 1'b1);
      coreConsume();
      coreLoad(~b);
      hostRead(1'b0, 1'b1, v, oe);
      chk("R5 byte pattern", v, ~b);
    end
    chk("R7 scoreboard empty", 8'(expQ.size()), 8'h00);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule